// File: doc/BRIEF.md
# Wrapping 32-Byte Burst Sequencer

This block turns a single cache-line fill or write-back request into the series of bus beats needed to move one 32-byte line over an external bus. The bus can be 8, 16, 32 or 64 bits wide. A request carries a byte address and a width code. The sequencer registers the request and presents one beat address at a time, with a valid strobe. It advances to the next beat only when the cycle engine acknowledges the current one.

The first beat targets the data that was actually asked for, with its address rounded down to the bus width. Each later beat steps forward by the bus width. When a step passes the end of the line, it wraps back to the start of the same 32-byte aligned line, so the upper address bits never change within a burst. A bus-ownership output rises with the first beat and stays high through every beat, so no other master can take the bus in the middle of a line. One cycle after the final acknowledge, a done pulse marks the end of the burst.

Top module: `burst_wrap_seq`

## Requirements
- R1: A burst presents exactly 32 / W beats, where W is the bus width in bytes. The width code is 0 for 8-bit (W=1), 1 for 16-bit (W=2), 2 for 32-bit (W=4) and 3 for 64-bit (W=8).
- R2: A request is accepted when `req_valid` is sampled high while no burst is running. On the next cycle `beat_valid` rises, and `beat_addr` equals `req_addr` with its low log2(W) bits cleared.
- R3: Each acknowledged beat that is not the last is followed by a beat whose address bits [4:0] equal the previous bits [4:0] plus W, modulo 32. Bits above bit 4 are unchanged.
- R4: `bus_own` is high in every cycle in which `beat_valid` is high. It stays high continuously until the cycle after the final beat is acknowledged, and in that cycle it drops.
- R5: `beat_last` is high exactly on the final beat of a burst. `burst_done` is a one-cycle pulse in the cycle after the final acknowledge.
- R6: While `beat_ack` is low, `beat_valid` and `beat_addr` hold their values.
- R7: `req_valid` is ignored while a burst is running. The beat sequence in progress is unchanged, and no further beats appear after its done pulse.
- R8: Synchronous reset returns the block to idle. In the cycle after a reset edge, `bus_own`, `beat_valid` and `burst_done` are low, even if a burst was in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Burst request strobe |
| req_addr | input | ADDR_W | Byte address of the requested data |
| req_width | input | 2 | Bus width code (0=8, 1=16, 2=32, 3=64 bits) |
| beat_valid | output | 1 | A beat address is presented |
| beat_addr | output | ADDR_W | Byte address of the current beat |
| beat_last | output | 1 | The current beat is the final one |
| beat_ack | input | 1 | Cycle engine has completed the current beat |
| bus_own | output | 1 | Bus held for the whole burst |
| burst_done | output | 1 | One-cycle pulse after the final acknowledge |

## Verification
The bench builds the block with ADDR_W set to 20. With that width, the start addresses in the tests have non-zero bits well above the 32-byte line. This shows that wrapping never carries into the upper field, including at a line that ends near the top of the address range. Every width code is exercised with a start offset chosen so that the burst wraps part-way through. Acknowledges arrive in an irregular pattern, with a long stall included, so the hold behaviour and the last-beat timing are observed under back-pressure.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int LINE_BYTES = 32;
  localparam int OFS_W      = $clog2(LINE_BYTES);
  localparam int CNT_W      = OFS_W + 1;

  typedef enum logic [1:0] {
    BW_8  = 2'd0,
    BW_16 = 2'd1,
    BW_32 = 2'd2,
    BW_64 = 2'd3
  } bw_e;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;

  // bytes moved per beat
  function automatic logic [OFS_W-1:0] step_bytes(input bw_e bw);
    return OFS_W'(1) << bw;
  endfunction

  // beats needed to move one line
  function automatic logic [CNT_W-1:0] line_beats(input bw_e bw);
    return CNT_W'(LINE_BYTES) >> bw;
  endfunction
endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             is_last
);
  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (rst)       remain_q <= '0;
    else if (load) remain_q <= load_val;
    else if (dec && remain_q != '0) remain_q <= remain_q - CNT_W'(1);
  end

  assign is_last = (remain_q == CNT_W'(1));
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  bw_e               load_bw,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output bw_e               cur_bw
);
  localparam int HI_W = ADDR_W - OFS_W;

  logic [HI_W-1:0]  line_q;
  logic [OFS_W-1:0] ofs_q;
  logic [OFS_W-1:0] align_mask;

  assign align_mask = ~(step_bytes(load_bw) - OFS_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= '0;
      ofs_q  <= '0;
      cur_bw <= BW_8;
    end else if (load) begin
      line_q <= load_addr[ADDR_W-1:OFS_W];
      ofs_q  <= load_addr[OFS_W-1:0] & align_mask;
      cur_bw <= load_bw;
    end else if (step) begin
      // OFS_W-bit add wraps inside the line
      ofs_q <= ofs_q + step_bytes(cur_bw);
    end
  end

  assign addr = {line_q, ofs_q};
endmodule

// File: rtl/burst_wrap_seq.sv
module burst_wrap_seq
  import burst_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_width,
  output logic              beat_valid,
  output logic [ADDR_W-1:0] beat_addr,
  output logic              beat_last,
  input  logic              beat_ack,
  output logic              bus_own,
  output logic              burst_done
);
  seq_state_e state_q;
  logic       accept, fire, finish, is_last;
  bw_e        req_bw, cur_bw;

  assign req_bw = bw_e'(req_width);
  assign accept = (state_q == SEQ_IDLE) && req_valid;
  assign fire   = beat_valid && beat_ack;
  assign finish = fire && is_last;

  burst_beat_ctr u_ctr (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .load_val (line_beats(req_bw)),
    .dec      (fire),
    .is_last  (is_last)
  );

  burst_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .clk       (clk),
    .rst       (rst),
    .load      (accept),
    .load_addr (req_addr),
    .load_bw   (req_bw),
    .step      (fire),
    .addr      (beat_addr),
    .cur_bw    (cur_bw)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= SEQ_IDLE;
      bus_own    <= 1'b0;
      burst_done <= 1'b0;
    end else begin
      burst_done <= finish;
      unique case (state_q)
        SEQ_IDLE: if (accept) begin
          state_q <= SEQ_RUN;
          bus_own <= 1'b1;
        end
        SEQ_RUN: if (finish) begin
          state_q <= SEQ_IDLE;
          bus_own <= 1'b0;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign beat_valid = (state_q == SEQ_RUN);
  assign beat_last  = beat_valid && is_last;
endmodule

// File: rtl/burst_wrap_seq_chk.sv
module burst_wrap_seq_chk
  import burst_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              beat_valid,
  input logic [ADDR_W-1:0] beat_addr,
  input logic              beat_last,
  input logic              beat_ack,
  input logic              bus_own,
  input logic              burst_done,
  input bw_e               cur_bw
);
  logic [3:0] wmask;
  assign wmask = (4'd1 << cur_bw) - 4'd1;

  // R2: beat address always aligned to the active width
  p_aligned_r2: assert property (@(posedge clk) disable iff (rst)
    beat_valid |-> ((beat_addr[2:0] & wmask[2:0]) == 3'd0));

  // R3: upper line bits unchanged across a step
  p_same_line_r3: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && beat_ack && !beat_last) |=>
      (beat_valid && beat_addr[ADDR_W-1:OFS_W] == $past(beat_addr[ADDR_W-1:OFS_W])));

  // R4: ownership covers every beat
  p_own_covers_r4: assert property (@(posedge clk) disable iff (rst)
    beat_valid |-> bus_own);

  // R4: ownership held until final acknowledge
  p_own_held_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_own && !(beat_ack && beat_last)) |=> bus_own);

  // R5: done pulse and release after last acknowledge
  p_done_after_last_r5: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && beat_ack && beat_last) |=> (burst_done && !bus_own && !beat_valid));

  // R5: done lasts one cycle
  p_done_single_r5: assert property (@(posedge clk) disable iff (rst)
    burst_done |=> !burst_done);

  // R6: hold while stalled
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && !beat_ack) |=> (beat_valid && $stable(beat_addr)));

  // R8: reset returns to idle
  p_reset_idle_r8: assert property (@(posedge clk)
    rst |=> (!bus_own && !beat_valid && !burst_done));
endmodule

bind burst_wrap_seq burst_wrap_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .beat_valid (beat_valid),
  .beat_addr  (beat_addr),
  .beat_last  (beat_last),
  .beat_ack   (beat_ack),
  .bus_own    (bus_own),
  .burst_done (burst_done),
  .cur_bw     (cur_bw)
);

// File: tb/burst_wrap_seq_tb_top.sv
module burst_wrap_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 20;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [1:0]        req_width = 2'd0;
  logic              beat_valid, beat_last, bus_own, burst_done;
  logic [ADDR_W-1:0] beat_addr;
  logic              beat_ack = 1'b0;

  int checks = 0;
  int fails  = 0;

  logic [ADDR_W-1:0] exp_q[$];
  int   exp_n = 0;
  int   beats_seen = 0;
  bit   burst_active = 0;
  bit   expect_done = 0;
  bit   mon_en = 0;
  bit   ack_hold = 0;
  logic [7:0] lfsr = 8'hA7;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_wrap_seq #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_width(req_width), .beat_valid(beat_valid), .beat_addr(beat_addr),
    .beat_last(beat_last), .beat_ack(beat_ack), .bus_own(bus_own),
    .burst_done(burst_done)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // driver: issue a burst and push its expected beats
  task automatic run_burst(input logic [ADDR_W-1:0] a, input logic [1:0] code);
    int wb = 1 << code;
    int n  = 32 / wb;
    logic [4:0] ofs = a[4:0] & ~5'(wb - 1);
    while (burst_active) @(negedge clk);
    for (int i = 0; i < n; i++)
      exp_q.push_back({a[ADDR_W-1:5], 5'(ofs + 5'(i * wb))});
    exp_n = n; beats_seen = 0; burst_active = 1;
    req_valid = 1'b1; req_addr = a; req_width = code;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor + acknowledge source
  initial begin
    forever begin
      @(negedge clk);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      beat_ack = mon_en ? (!ack_hold && (lfsr[0] || lfsr[3])) : 1'b1;
      if (mon_en) begin
        if (expect_done) begin
          check(burst_done && !bus_own, "R5 done/R4 release", {burst_done, bus_own}, 2'b10);
          check(beats_seen == exp_n, "R1 beat count", beats_seen, exp_n);
          expect_done = 0; burst_active = 0;
        end
        if (beat_valid) begin
          check(bus_own, "R4 ownership", bus_own, 1);
          if (exp_q.size() == 0) check(0, "R7 unexpected beat", beat_addr, 0);
          else begin
            check(beat_addr == exp_q[0],
                  !beat_ack ? "R6 hold" : (beats_seen == 0 ? "R2 first beat" : "R3 wrap step"),
                  beat_addr, exp_q[0]);
            check(beat_last == (exp_q.size() == 1), "R5 last flag", beat_last, exp_q.size() == 1);
            if (beat_ack) begin
              void'(exp_q.pop_front());
              beats_seen++;
              if (exp_q.size() == 0) expect_done = 1;
            end
          end
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!bus_own && !beat_valid && !burst_done, "R8 reset state",
          {bus_own, beat_valid, burst_done}, 0);
    mon_en = 1;

    run_burst(20'hA1234, 2'd0);            // R1 32 beats, R3 wrap from 0x14
    run_burst(20'h5A5F6, 2'd1);            // 16 beats from 0x16
    // R7: request during a burst is ignored
    run_burst(20'h00C1F, 2'd2);            // R2 aligned to 0x1C
    @(negedge clk);
    req_valid = 1'b1; req_addr = 20'h77700; req_width = 2'd0;
    repeat (2) @(negedge clk);
    req_valid = 1'b0;
    while (burst_active) @(negedge clk);
    repeat (3) begin
      @(negedge clk);
      check(!beat_valid && !bus_own, "R7 no extra burst", beat_valid, 0);
    end
    // R6: long stall mid burst
    run_burst(20'hFFFEB, 2'd3);            // 64-bit, aligned 0x08, top line
    @(negedge clk);
    ack_hold = 1;
    repeat (6) @(negedge clk);
    ack_hold = 0;
    run_burst(20'h3C007, 2'd1);
    run_burst(20'h12345, 2'd3);
    while (burst_active) @(negedge clk);

    // R8: reset during a burst
    mon_en = 0;
    req_valid = 1'b1; req_addr = 20'h0BEE2; req_width = 2'd0;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(bus_own, "R8 burst running before reset", bus_own, 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(!bus_own && !beat_valid && !burst_done, "R8 reset mid burst",
          {bus_own, beat_valid, burst_done}, 0);
    exp_q.delete(); burst_active = 0; expect_done = 0;
    @(negedge clk);
    mon_en = 1;
    run_burst(20'h4445C, 2'd2);            // recovery after reset
    while (burst_active) @(negedge clk);
    repeat (2) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule